// File: doc/BRIEF.md
# Closed-Loop Whole-Array Erase Sequencer

This controller erases every byte of a byte-addressed, flash-style array and proves the result by reading the array back. A run begins when `start` is strobed. The sequencer first reads from address zero upward. If every byte up to `arr_last` already reads FFH, it reports success at once and applies no pulse. If it finds a byte that is not erased, it conditions the whole range to 00H. To do this it programs each byte with a closed loop of pulses, reading the byte back after every pulse. Only after that does it issue erase pulses.

After each erase pulse a verify sweep reads bytes and looks for FFH. The sweep halts at the first byte that is still not erased, and another erase pulse follows. The address where the sweep halted is kept in a register, and the next sweep restarts there instead of at zero. Because of this, the verify reads in the erase phase total the range size plus one read per extra pulse. Pulse widths and retry limits are parameters. Two consecutive command writes of FFH during a run cancel it cleanly. The array itself is external, reached through a simple read/pulse port.

Top module: `erase_seq`

## Requirements
- R1: After `start`, bytes are read from address 0 upward until the first byte that is not FFH. If all bytes 0..`arr_last` read FFH, the run ends with pass, `erase_pulses`=0, and no program or erase pulse.
- R2: Before the first erase pulse, every byte 0..`arr_last` (and no byte above it), in ascending order, receives program pulses (`mem_prog` high for PROG_W cycles), each followed by one read, until it reads 00H.
- R3: A byte still not reading 00H after PROG_MAX program pulses ends the run with fail, and no erase pulse is ever issued in that run.
- R4: Every erase pulse keeps `mem_erase` high for exactly ERASE_W cycles, and every program pulse keeps `mem_prog` high for PROG_W cycles. The two are never high together. Only a cancel may cut a pulse short.
- R5: After each erase pulse, reading resumes at the stored address and proceeds upward. The first byte that is not FFH stops the sweep and triggers another pulse, and the stored address never moves backward. Erase-phase reads therefore total (`arr_last`+1) + (pulses − 1).
- R6: The run passes when a sweep reads FFH at `arr_last`. `erase_pulses` then equals the number of erase pulses issued, which is the largest pulse count any byte in range needed.
- R7: If the sweep still fails after ERASE_MAX pulses, the run ends with fail and `erase_pulses` = ERASE_MAX.
- R8: While busy, two `cmd_we` writes of FFH with no other write between them end the run at that clock edge, with `aborted`. No further pulse follows. A write of any other value between the two resets the pair.
- R9: `done` is a one-cycle pulse carrying exactly one of pass/fail/aborted, and these levels hold until the next `start`. While idle, and from reset, all memory strobes and result outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken when idle) |
| arr_last | input | ADDR_W | Highest address in the range |
| cmd_we | input | 1 | Command write strobe |
| cmd_byte | input | 8 | Command byte value |
| mem_addr | output | ADDR_W | Array address |
| mem_rd | output | 1 | Read request; data is expected on `mem_rdata` the next cycle |
| mem_rdata | input | 8 | Read data |
| mem_prog | output | 1 | Program pulse to 00H at `mem_addr` |
| mem_erase | output | 1 | Whole-array erase pulse |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion strobe |
| pass | output | 1 | Run succeeded |
| fail | output | 1 | Run gave up |
| aborted | output | 1 | Run cancelled by command |
| erase_pulses | output | EC_W | Erase pulses issued in the run |

## Verification
Each read returns data one cycle after `mem_rd`, and the decision on that data registers at the next edge. A final `done` therefore appears two cycles after the last `mem_rd` cycle. A cancel shows `done` and `aborted` one cycle after the edge that takes the second FFH write. The bench drives on falling edges and samples on falling edges. For a full run it polls for `done` and compares every result in that same cycle. For a cancel it samples in the falling edge that follows the second write. Program, erase and read counts are taken from a bench memory model and compared with totals that the bench derives from each vector's per-byte pulse needs.

// File: rtl/esq_pkg.sv
package esq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SCAN_RD,
    S_SCAN_CHK,
    S_PP_PULSE,
    S_PP_RD,
    S_PP_CHK,
    S_ER_PULSE,
    S_EV_RD,
    S_EV_CHK
  } esq_state_e;

  localparam logic [7:0] BYTE_BLANK  = 8'hFF;
  localparam logic [7:0] BYTE_ZEROED = 8'h00;
  localparam logic [7:0] CANCEL_CODE = 8'hFF;

  function automatic logic is_blank(input logic [7:0] d);
    return d == BYTE_BLANK;
  endfunction

  function automatic logic is_zeroed(input logic [7:0] d);
    return d == BYTE_ZEROED;
  endfunction

  // true once the number of attempts used has reached its ceiling
  function automatic logic spent(input int unsigned used, input int unsigned ceiling);
    return used >= ceiling;
  endfunction

  function automatic int unsigned bits_for(input int unsigned maxval);
    return $clog2(maxval + 1);
  endfunction

endpackage

// File: rtl/esq_pulse_timer.sv
module esq_pulse_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] len_m1,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign last = run && (cnt_q == len_m1);
endmodule

// File: rtl/esq_cancel_det.sv
module esq_cancel_det
  import esq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       we,
  input  logic [7:0] wbyte,
  output logic       hit
);
  logic prev_code_q;
  logic is_code;

  assign is_code = (wbyte == CANCEL_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   prev_code_q <= 1'b0;
    else if (clr) prev_code_q <= 1'b0;
    else if (we)  prev_code_q <= is_code;
  end

  assign hit = we && is_code && prev_code_q;
endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import esq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned PROG_W    = 1000,
  parameter int unsigned ERASE_W   = 1000000,
  parameter int unsigned PROG_MAX  = 25,
  parameter int unsigned ERASE_MAX = 1000,
  localparam int unsigned EC_W     = $clog2(ERASE_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] arr_last,
  input  logic              cmd_we,
  input  logic [7:0]        cmd_byte,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata,
  output logic              mem_prog,
  output logic              mem_erase,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic              aborted,
  output logic [EC_W-1:0]   erase_pulses
);
  localparam int unsigned WMAX = (ERASE_W > PROG_W) ? ERASE_W : PROG_W;
  localparam int unsigned TW   = $clog2(WMAX) + 1;
  localparam int unsigned PC_W = $clog2(PROG_MAX + 1);
  localparam logic [TW-1:0] PROG_LEN_M1  = TW'(PROG_W - 1);
  localparam logic [TW-1:0] ERASE_LEN_M1 = TW'(ERASE_W - 1);

  esq_state_e state_q;
  logic [ADDR_W-1:0] cur_q;      // scan / pre-program address
  logic [ADDR_W-1:0] resume_q;   // stored verify address
  logic [PC_W-1:0]   pc_q;       // program pulses spent on cur_q
  logic [EC_W-1:0]   ec_q;       // erase pulses issued
  logic done_q, pass_q, fail_q, abort_q;

  // named internal events
  logic in_pulse, pulse_end, cancel_hit, cancel_now;
  logic ev_scan_dirty, ev_scan_end;
  logic ev_pp_ok, ev_pp_giveup, ev_pp_last;
  logic ev_ev_ok, ev_ev_miss, ev_ev_last, ev_er_giveup;

  assign busy      = (state_q != S_IDLE);
  assign in_pulse  = (state_q == S_PP_PULSE) || (state_q == S_ER_PULSE);
  assign mem_prog  = (state_q == S_PP_PULSE);
  assign mem_erase = (state_q == S_ER_PULSE);
  assign mem_rd    = (state_q == S_SCAN_RD) || (state_q == S_PP_RD) || (state_q == S_EV_RD);
  assign mem_addr  = (state_q == S_ER_PULSE || state_q == S_EV_RD || state_q == S_EV_CHK)
                     ? resume_q : cur_q;

  esq_pulse_timer #(.CW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (in_pulse),
    .len_m1 (mem_prog ? PROG_LEN_M1 : ERASE_LEN_M1),
    .last   (pulse_end)
  );

  esq_cancel_det u_cancel (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start && !busy),
    .we    (cmd_we),
    .wbyte (cmd_byte),
    .hit   (cancel_hit)
  );

  assign cancel_now = busy && cancel_hit;

  assign ev_scan_dirty = (state_q == S_SCAN_CHK) && !is_blank(mem_rdata);
  assign ev_scan_end   = (state_q == S_SCAN_CHK) && is_blank(mem_rdata) && (cur_q == arr_last);
  assign ev_pp_ok      = (state_q == S_PP_CHK) && is_zeroed(mem_rdata);
  assign ev_pp_last    = ev_pp_ok && (cur_q == arr_last);
  assign ev_pp_giveup  = (state_q == S_PP_CHK) && !is_zeroed(mem_rdata)
                         && spent(32'(pc_q), PROG_MAX);
  assign ev_ev_ok      = (state_q == S_EV_CHK) && is_blank(mem_rdata);
  assign ev_ev_last    = ev_ev_ok && (resume_q == arr_last);
  assign ev_ev_miss    = (state_q == S_EV_CHK) && !is_blank(mem_rdata);
  assign ev_er_giveup  = ev_ev_miss && spent(32'(ec_q), ERASE_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      cur_q    <= '0;
      resume_q <= '0;
      pc_q     <= '0;
      ec_q     <= '0;
      done_q   <= 1'b0;
      pass_q   <= 1'b0;
      fail_q   <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cancel_now) begin
        state_q <= S_IDLE;
        done_q  <= 1'b1;
        abort_q <= 1'b1;
      end else begin
        unique case (state_q)
          S_IDLE: begin
            if (start) begin
              state_q  <= S_SCAN_RD;
              cur_q    <= '0;
              resume_q <= '0;
              pc_q     <= '0;
              ec_q     <= '0;
              pass_q   <= 1'b0;
              fail_q   <= 1'b0;
              abort_q  <= 1'b0;
            end
          end
          S_SCAN_RD: state_q <= S_SCAN_CHK;
          S_SCAN_CHK: begin
            if (ev_scan_dirty) begin
              cur_q   <= '0;
              pc_q    <= '0;
              state_q <= S_PP_PULSE;
            end else if (ev_scan_end) begin
              state_q <= S_IDLE;
              done_q  <= 1'b1;
              pass_q  <= 1'b1;
            end else begin
              cur_q   <= cur_q + 1'b1;
              state_q <= S_SCAN_RD;
            end
          end
          S_PP_PULSE: begin
            if (pulse_end) begin
              pc_q    <= pc_q + 1'b1;
              state_q <= S_PP_RD;
            end
          end
          S_PP_RD: state_q <= S_PP_CHK;
          S_PP_CHK: begin
            if (ev_pp_last) begin
              resume_q <= '0;
              ec_q     <= EC_W'(1);
              state_q  <= S_ER_PULSE;
            end else if (ev_pp_ok) begin
              cur_q   <= cur_q + 1'b1;
              pc_q    <= '0;
              state_q <= S_PP_PULSE;
            end else if (ev_pp_giveup) begin
              state_q <= S_IDLE;
              done_q  <= 1'b1;
              fail_q  <= 1'b1;
            end else begin
              state_q <= S_PP_PULSE;
            end
          end
          S_ER_PULSE: if (pulse_end) state_q <= S_EV_RD;
          S_EV_RD: state_q <= S_EV_CHK;
          S_EV_CHK: begin
            if (ev_ev_last) begin
              state_q <= S_IDLE;
              done_q  <= 1'b1;
              pass_q  <= 1'b1;
            end else if (ev_ev_ok) begin
              resume_q <= resume_q + 1'b1;
              state_q  <= S_EV_RD;
            end else if (ev_er_giveup) begin
              state_q <= S_IDLE;
              done_q  <= 1'b1;
              fail_q  <= 1'b1;
            end else begin
              ec_q    <= ec_q + 1'b1;
              state_q <= S_ER_PULSE;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign done         = done_q;
  assign pass         = pass_q;
  assign fail         = fail_q;
  assign aborted      = abort_q;
  assign erase_pulses = ec_q;
endmodule

// File: rtl/esq_checker.sv
module esq_checker #(
  parameter int unsigned AW        = 8,
  parameter int unsigned EC_W      = 10,
  parameter int unsigned ERASE_W   = 16,
  parameter int unsigned ERASE_MAX = 1000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            pass,
  input logic            fail,
  input logic            aborted,
  input logic            mem_prog,
  input logic            mem_erase,
  input logic            mem_rd,
  input logic [EC_W-1:0] erase_pulses,
  input logic [AW-1:0]   resume
);
  int unsigned ew_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ew_cnt <= 0;
    else if (mem_erase) ew_cnt <= ew_cnt + 1;
    else                ew_cnt <= 0;
  end

  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_prog && mem_erase));

  p_erase_not_long_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_erase |-> ew_cnt < ERASE_W);

  p_erase_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_erase) && !aborted) |-> ew_cnt == ERASE_W);

  p_resume_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> resume >= $past(resume));

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_erase) |-> erase_pulses == $past(erase_pulses) + 1'b1);

  p_count_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(erase_pulses) <= ERASE_MAX);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_prog || mem_erase || mem_rd));

  p_done_one_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({pass, fail, aborted}) == 1);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_leaves_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind erase_seq esq_checker #(
  .AW(ADDR_W), .EC_W(EC_W), .ERASE_W(ERASE_W), .ERASE_MAX(ERASE_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .pass(pass), .fail(fail),
  .aborted(aborted), .mem_prog(mem_prog), .mem_erase(mem_erase), .mem_rd(mem_rd),
  .erase_pulses(erase_pulses), .resume(resume_q)
);

// File: tb/sim_erase_seq.sv
module sim_erase_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4, PW = 3, EW = 5, PMAX = 4, EMAX = 8;
  localparam int ECW = $clog2(EMAX + 1);
  localparam int NB = 1 << AW;

  typedef struct packed {
    logic [3:0] last;
    logic       dirty;
    logic [3:0] dirty_idx;
    logic [3:0] er_base;
    logic [3:0] er_spread;
    logic [2:0] pg_need;
    logic [3:0] bad_idx;
    logic [2:0] bad_need;
    logic       exp_pass;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{4'd15, 1'b0, 4'd0,  4'd1, 4'd0, 3'd1, 4'd0, 3'd1, 1'b1},  // R1 already blank
    '{4'd15, 1'b1, 4'd0,  4'd1, 4'd0, 3'd1, 4'd0, 3'd1, 1'b1},  // one pulse
    '{4'd15, 1'b1, 4'd5,  4'd2, 4'd3, 3'd2, 4'd0, 3'd2, 1'b1},  // staggered needs R5
    '{4'd7,  1'b1, 4'd7,  4'd3, 4'd4, 3'd1, 4'd3, 3'd4, 1'b1},  // sub-range, prog at limit
    '{4'd15, 1'b1, 4'd2,  4'd1, 4'd0, 3'd1, 4'd9, 3'd5, 1'b0},  // R3 prog give-up
    '{4'd15, 1'b1, 4'd0,  4'd6, 4'd4, 3'd1, 4'd0, 3'd1, 1'b0},  // R7 erase give-up
    '{4'd3,  1'b1, 4'd3,  4'd8, 4'd0, 3'd1, 4'd0, 3'd1, 1'b1}   // erase at limit
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cmd_we = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [AW-1:0] arr_last = '0;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_prog, mem_erase, busy, done, pass, fail, aborted;
  logic [7:0] mem_rdata = 8'h00;
  logic [ECW-1:0] erase_pulses;

  always #(CLK_PERIOD / 2) clk = ~clk;

  erase_seq #(.ADDR_W(AW), .PROG_W(PW), .ERASE_W(EW), .PROG_MAX(PMAX), .ERASE_MAX(EMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .arr_last(arr_last), .cmd_we(cmd_we),
    .cmd_byte(cmd_byte), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .mem_prog(mem_prog), .mem_erase(mem_erase), .busy(busy), .done(done), .pass(pass),
    .fail(fail), .aborted(aborted), .erase_pulses(erase_pulses)
  );

  // behavioural array model
  logic [7:0] mem [NB];
  int ner [NB], npg [NB], pgc [NB];
  int er_total = 0, reads = 0, width_bad = 0, er_run = 0, pg_run = 0;
  logic prog_d = 1'b0, erase_d = 1'b0;

  always @(posedge clk) begin
    if (mem_rd) begin mem_rdata <= mem[mem_addr]; reads <= reads + 1; end
    if (mem_prog && !prog_d) begin
      pgc[mem_addr] <= pgc[mem_addr] + 1;
      if (pgc[mem_addr] + 1 >= npg[mem_addr]) mem[mem_addr] <= 8'h00;
    end
    if (mem_erase && !erase_d) begin
      er_total <= er_total + 1;
      for (int i = 0; i < NB; i++) if (er_total + 1 >= ner[i]) mem[i] <= 8'hFF;
    end
    prog_d <= mem_prog; erase_d <= mem_erase;
    if (mem_erase) er_run <= er_run + 1;
    else begin
      if (er_run != 0 && er_run != EW && !aborted) width_bad <= width_bad + 1;
      er_run <= 0;
    end
    if (mem_prog) pg_run <= pg_run + 1;
    else begin
      if (pg_run != 0 && pg_run != PW && !aborted) width_bad <= width_bad + 1;
      pg_run <= 0;
    end
  end

  int n_checks = 0, n_errors = 0;
  int exp_k, exp_reads, exp_prog; logic exp_ok;

  task automatic chk(input string req, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic load_model(input vec_t v);
    for (int i = 0; i < NB; i++) begin
      mem[i] = 8'hFF;
      ner[i] = int'(v.er_base) + (i % (int'(v.er_spread) + 1));
      npg[i] = (i == int'(v.bad_idx)) ? int'(v.bad_need) : int'(v.pg_need);
      pgc[i] = 0;
    end
    if (v.dirty) mem[v.dirty_idx] = 8'h3C;
    er_total = 0; reads = 0; width_bad = 0;
  endtask

  // expected totals derived from the requirements
  task automatic predict(input vec_t v);
    int last, va;
    last = int'(v.last);
    exp_k = 0; exp_prog = 0; exp_ok = 1'b1;
    if (!v.dirty) begin exp_reads = last + 1; return; end
    exp_reads = int'(v.dirty_idx) + 1;
    for (int i = 0; i <= last; i++) begin
      if (npg[i] > PMAX) begin
        exp_reads += PMAX; exp_prog += PMAX; exp_ok = 1'b0; return;
      end
      exp_reads += npg[i]; exp_prog += npg[i];
    end
    va = 0;
    for (int j = 1; j <= EMAX; j++) begin
      exp_k = j;
      while (va <= last) begin
        exp_reads++;
        if (ner[va] <= j) va++; else break;
      end
      if (va > last) return;
      if (j == EMAX) exp_ok = 1'b0;
    end
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk); cmd_we = 1'b1; cmd_byte = b;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic kick(input logic [3:0] last);
    arr_last = last;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk({req, " done seen"}, int'(done), 1);
  endtask

  function automatic int prog_sum();
    int s; s = 0;
    for (int i = 0; i < NB; i++) s += pgc[i];
    return s;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    load_model(VECS[0]);
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset busy", int'(busy), 0);
    chk("R9 reset strobes", int'({mem_prog, mem_erase, mem_rd}), 0);
    chk("R9 reset results", int'({done, pass, fail, aborted}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 idle after reset", int'({busy, done, pass, fail, aborted, erase_pulses}), 0);

    for (int v = 0; v < NV; v++) begin
      load_model(VECS[v]);
      predict(VECS[v]);
      kick(VECS[v].last);
      wait_done("R9");
      chk("R1/R3/R6/R7 pass flag", int'(pass), int'(VECS[v].exp_pass));
      chk("R1/R3/R6/R7 pass matches model", int'(pass), int'(exp_ok));
      chk("R3/R7 fail flag", int'(fail), int'(!VECS[v].exp_pass));
      chk("R6 R7 erase_pulses", int'(erase_pulses), exp_k);
      chk("R6 erase pulses seen by array", er_total, exp_k);
      chk("R5 total reads", reads, exp_reads);
      chk("R2 program pulses", prog_sum(), exp_prog);
      chk("R4 pulse widths", width_bad, 0);
      for (int i = int'(VECS[v].last) + 1; i < NB; i++)
        chk("R2 untouched above range", pgc[i], 0);
      if (pass)
        for (int i = 0; i <= int'(VECS[v].last); i++)
          chk("R6 byte blank", int'(mem[i]), 255);
      if (v == 0) begin
        chk("R1 no program pulse", prog_sum(), 0);
        chk("R1 reads whole range", reads, 16);
      end
      if (v == 4) chk("R3 no erase after give-up", er_total, 0);
      if (v == 5) chk("R7 capped count", int'(erase_pulses), EMAX);
      repeat (6) @(negedge clk);
      chk("R9 result held", int'(pass), int'(VECS[v].exp_pass));
    end

    // R8 cancel during scan: memory untouched
    load_model('{4'd15, 1'b1, 4'd15, 4'd1, 4'd0, 3'd1, 4'd0, 3'd1, 1'b1});
    kick(4'd15);
    repeat (3) @(negedge clk);
    send_cmd(8'hFF);
    send_cmd(8'hFF);
    chk("R8 cancel done", int'(done), 1);
    chk("R8 cancel flag", int'(aborted), 1);
    chk("R8 cancel not pass/fail", int'({pass, fail}), 0);
    chk("R8 byte kept", int'(mem[15]), 8'h3C);
    chk("R8 no pulses", prog_sum() + er_total, 0);

    // R8 split pair does not cancel
    load_model(VECS[1]);
    predict(VECS[1]);
    kick(4'd15);
    send_cmd(8'hFF);
    send_cmd(8'h00);
    send_cmd(8'hFF);
    wait_done("R8 split");
    chk("R8 split pair ignored", int'({pass, aborted}), 2);

    // R8 cancel during erase phase
    load_model(VECS[5]);
    kick(4'd15);
    while (er_total < 2) @(negedge clk);
    send_cmd(8'hFF);
    send_cmd(8'hFF);
    chk("R8 cancel in erase", int'({done, aborted}), 3);
    begin
      int snap;
      snap = er_total;
      repeat (40) @(negedge clk);
      chk("R8 no pulse after cancel", er_total, snap);
      chk("R8 erase strobe low", int'(mem_erase), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule